// File: doc/BRIEF.md
# Byte-Serial Reciprocal Square Root Engine

This block computes an approximate single-precision reciprocal square root, 1/sqrt(x), of one FP32 operand. The operand is streamed in as bytes on a narrow input bus. A strobe qualifies each byte, and the sender may pause between bytes. The engine forms a starting estimate with an integer bit trick: it subtracts half of the operand's magnitude bits from a constant. It then performs one Newton-Raphson step on a reduced-precision datapath and streams the FP32 result back out as bytes. A valid flag marks the result bytes and a last flag marks the final one.

Only one operand is in flight at a time. After the last input byte the engine spends a fixed four cycles on arithmetic, which keeps the timing fully predictable for the sender. The four arithmetic cycles share one truncated multiplier and one fixed-point "1.5 minus b" stage. Inputs that have no finite positive answer are detected up front and replaced by fixed IEEE codes.

Top module: `rsq_byte_engine`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears `out_valid` and `out_last` to 0, discards any partly received operand and returns the engine to waiting for a first byte.
- R2: While waiting, a byte on `in_byte` is captured only at a rising edge where `in_valid` is 1. Bytes form the operand most-significant byte first, and any number of idle cycles may sit between bytes.
- R3: The first result byte is presented in the cycle that follows the fourth rising edge after the edge that captured the last operand byte. `out_valid` stays 0 in the four cycles before it.
- R4: The result is presented on four consecutive cycles, most-significant byte first, with `out_valid` 1 on all four and `out_last` 1 only on the fourth. `out_valid` is 0 in the cycle after that.
- R5: The estimate uses bits [30:0] y0 = SEED_MAGIC - (x[30:0] >> 1), with SEED_MAGIC defaulting to 0x5F3759DF and the sign bit 0. Exactly one refinement y1 = y0 * (1.5 - 0.5 * x * y0 * y0) is applied, and every operand mantissa is cut to its top PRECISION_BITS fraction bits.
- R6: For a positive normal operand the result has sign 0 and an exponent field that is neither 0 nor 255. Its relative error against the exact 1/sqrt(x) is at most 0.00175 + 10 * 2^-PRECISION_BITS.
- R7: Any NaN operand (exponent field 255, non-zero fraction, either sign) gives 0x7FC00000. This check takes priority over all others.
- R8: Any zero or subnormal operand (exponent field 0, either sign) gives 0x7F800000.
- R9: A negative operand that is not covered by R7 or R8, which includes negative infinity, gives 0x7FC00000.
- R10: Positive infinity (0x7F800000) gives 0x00000000.
- R11: `in_valid` pulses during the four arithmetic cycles or the four output cycles are ignored. They neither change the result being produced nor shift the bytes of the next operand.
- R12: The first byte of the next operand can be captured at the rising edge that ends the cycle right after the last result byte, so operands may run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_byte | input | BYTE_W | Operand byte, most-significant byte first |
| in_valid | input | 1 | Qualifies `in_byte` at the current rising edge |
| out_byte | output | BYTE_W | Result byte, most-significant byte first |
| out_valid | output | 1 | High while a result byte is presented |
| out_last | output | 1 | High with the final result byte |

## Verification
The bench builds the engine with PRECISION_BITS = 11, BYTE_W = 8 and the default seed constant. At these settings the error bound of R6 is tight enough to expose a wrong seed, a skipped refinement or a misplaced mantissa cut. The bench sweeps every normal exponent (1 to 254) with eight fraction patterns and compares each result against a real-valued 1/sqrt reference. Along the way it varies the byte gaps, includes back-to-back operands and injects strobe noise while the engine is busy. A fixed list of zeros, subnormals, negatives, infinities and NaNs checks the special codes and their priority.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef struct packed {
      logic        sign;
      logic [7:0]  expo;
      logic [22:0] frac;
   } fp32_t;

   typedef enum logic [1:0] {
      ST_RECV = 2'd0,
      ST_CALC = 2'd1,
      ST_SEND = 2'd2
   } rsq_state_e;

   localparam logic [31:0] FP_QNAN = 32'h7FC0_0000;
   localparam logic [31:0] FP_PINF = 32'h7F80_0000;
   localparam logic [31:0] FP_ZERO = 32'h0000_0000;
   localparam int          FP_BIAS = 127;

endpackage

// File: rtl/rsq_rx.sv
module rsq_rx #(
   parameter int BYTE_W = 8,
   parameter int BYTES  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      in_valid,
   input  logic [BYTE_W-1:0]         in_byte,
   output logic [BYTE_W*BYTES-1:0]   word,
   output logic                      done
);
   localparam int WORD_W = BYTE_W * BYTES;
   localparam int CNT_W  = $clog2(BYTES);

   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign take = en && in_valid;
   assign done = take && (cnt_q == CNT_W'(BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         word  <= '0;
      end else if (take) begin
         word  <= {word[WORD_W-BYTE_W-1:0], in_byte};
         cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/rsq_mul.sv
module rsq_mul
   import rsq_pkg::*;
#(
   parameter int PRECISION_BITS = 11
) (
   input  fp32_t a,
   input  fp32_t b,
   output fp32_t p
);
   localparam int MW = PRECISION_BITS + 1;
   localparam int PW = 2 * MW;

   logic [MW-1:0]             ma, mb;
   logic [PW-1:0]             prod;
   logic [9:0]                esum, ex;
   logic [PRECISION_BITS-1:0] fr;
   logic                      unused_mul;

   always_comb begin
      ma   = {1'b1, a.frac[22 -: PRECISION_BITS]};
      mb   = {1'b1, b.frac[22 -: PRECISION_BITS]};
      prod = PW'(ma) * PW'(mb);
      esum = {2'b00, a.expo} + {2'b00, b.expo} - 10'(FP_BIAS);
      if (prod[PW-1]) begin
         fr = prod[PW-2 -: PRECISION_BITS];
         ex = esum + 10'd1;
      end else begin
         fr = prod[PW-3 -: PRECISION_BITS];
         ex = esum;
      end
      p                          = '0;
      p.expo                     = ex[7:0];
      p.frac[22 -: PRECISION_BITS] = fr;
   end

   assign unused_mul = ^{a.sign, b.sign, a.frac, b.frac, ex[9:8], prod};
endmodule

// File: rtl/rsq_sub.sv
module rsq_sub
   import rsq_pkg::*;
#(
   parameter int PRECISION_BITS = 11
) (
   input  fp32_t b,
   output fp32_t d_out
);
   localparam int FB = PRECISION_BITS + 2;
   localparam int DW = FB + 2;
   localparam logic [DW-1:0] THREE_HALF = DW'(3) << (FB - 1);

   logic [PRECISION_BITS:0]   mant;
   logic [DW-1:0]             bf, diff, norm;
   logic                      unused_sub;
   int                        e_i, lead;

   always_comb begin
      mant = {1'b1, b.frac[22 -: PRECISION_BITS]};
      e_i  = int'(b.expo);
      if (e_i >= 125)
         bf = DW'(mant) << (e_i - 125);
      else
         bf = DW'(mant) >> (125 - e_i);
      diff = THREE_HALF - bf;
      lead = 0;
      for (int i = 0; i < DW; i++)
         if (diff[i]) lead = i;
      norm  = diff << (FB - lead);
      d_out = '0;
      if (e_i <= 127 && bf < THREE_HALF) begin
         d_out.expo                     = 8'(FP_BIAS + lead - FB);
         d_out.frac[22 -: PRECISION_BITS] = norm[FB-1 -: PRECISION_BITS];
      end
   end

   assign unused_sub = ^{b.sign, b.frac, norm};
endmodule

// File: rtl/rsq_tx.sv
module rsq_tx #(
   parameter int BYTE_W = 8,
   parameter int BYTES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [BYTE_W*BYTES-1:0] word,
   output logic [BYTE_W-1:0]       out_byte,
   output logic                    out_valid,
   output logic                    out_last
);
   localparam int WORD_W = BYTE_W * BYTES;
   localparam int CNT_W  = $clog2(BYTES);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              act_q;

   assign out_byte  = sh_q[WORD_W-1 -: BYTE_W];
   assign out_valid = act_q;
   assign out_last  = act_q && (cnt_q == CNT_W'(BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (load) begin
         sh_q  <= word;
         cnt_q <= '0;
         act_q <= 1'b1;
      end else if (act_q) begin
         sh_q  <= sh_q << BYTE_W;
         cnt_q <= cnt_q + CNT_W'(1);
         if (out_last) act_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rsq_byte_engine.sv
module rsq_byte_engine
   import rsq_pkg::*;
#(
   parameter int          PRECISION_BITS = 11,
   parameter int          BYTE_W         = 8,
   parameter logic [30:0] SEED_MAGIC     = 31'h5F3759DF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_valid,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_valid,
   output logic              out_last
);
   localparam int BYTES = 32 / BYTE_W;

   if (PRECISION_BITS < 4 || PRECISION_BITS > 23) begin : g_bad_precision
      $error("rsq_byte_engine: PRECISION_BITS must lie in 4..23");
   end
   if (BYTE_W != 4 && BYTE_W != 8 && BYTE_W != 16) begin : g_bad_byte
      $error("rsq_byte_engine: BYTE_W must be 4, 8 or 16");
   end

   rsq_state_e  state_q;
   logic [1:0]  step_q;
   logic [31:0] x_bits;
   logic        rx_done, tx_load;
   fp32_t       x_w, y0_w, acc_q, mul_a, mul_b, mul_p, half_w, sub_w, final_w;
   logic        is_nan, is_zsub, is_neg, is_pinf;

   rsq_rx #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(state_q == ST_RECV),
      .in_valid(in_valid), .in_byte(in_byte),
      .word(x_bits), .done(rx_done)
   );

   assign x_w  = x_bits;
   assign y0_w = {1'b0, SEED_MAGIC - {1'b0, x_bits[30:1]}};

   always_comb begin
      case (step_q)
         2'd0:    begin mul_a = x_w;   mul_b = y0_w;  end
         2'd1:    begin mul_a = acc_q; mul_b = y0_w;  end
         default: begin mul_a = y0_w;  mul_b = acc_q; end
      endcase
   end

   rsq_mul #(.PRECISION_BITS(PRECISION_BITS)) u_mul (
      .a(mul_a), .b(mul_b), .p(mul_p)
   );

   rsq_sub #(.PRECISION_BITS(PRECISION_BITS)) u_sub (
      .b(acc_q), .d_out(sub_w)
   );

   assign half_w = {mul_p.sign, mul_p.expo - 8'd1, mul_p.frac};

   assign is_nan  = (x_w.expo == 8'hFF) && (x_w.frac != '0);
   assign is_zsub = (x_w.expo == 8'h00);
   assign is_neg  = x_w.sign;
   assign is_pinf = (x_w.expo == 8'hFF) && (x_w.frac == '0) && !x_w.sign;

   always_comb begin
      if (is_nan)       final_w = FP_QNAN;
      else if (is_zsub) final_w = FP_PINF;
      else if (is_neg)  final_w = FP_QNAN;
      else if (is_pinf) final_w = FP_ZERO;
      else              final_w = mul_p;
   end

   assign tx_load = (state_q == ST_CALC) && (step_q == 2'd3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RECV;
         step_q  <= 2'd0;
         acc_q   <= '0;
      end else begin
         case (state_q)
            ST_RECV: begin
               step_q <= 2'd0;
               if (rx_done) state_q <= ST_CALC;
            end
            ST_CALC: begin
               step_q <= step_q + 2'd1;
               case (step_q)
                  2'd0:    acc_q <= mul_p;
                  2'd1:    acc_q <= half_w;
                  2'd2:    acc_q <= sub_w;
                  default: state_q <= ST_SEND;
               endcase
            end
            ST_SEND: begin
               if (out_last) state_q <= ST_RECV;
            end
            default: state_q <= ST_RECV;
         endcase
      end
   end

   rsq_tx #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .word(final_w),
      .out_byte(out_byte), .out_valid(out_valid), .out_last(out_last)
   );
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BYTE_W-1:0] out_byte,
   input logic              out_valid,
   input logic              out_last
);
   localparam int BYTES = 32 / BYTE_W;
   localparam int CNT_W = $clog2(BYTES) + 1;

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         run_q <= '0;
      else if (out_valid) run_q <= out_last ? '0 : run_q + CNT_W'(1);
      else                run_q <= '0;
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !out_last));

   // R4
   last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R4
   burst_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   // R4
   idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);

   // R4
   burst_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (run_q == CNT_W'(BYTES - 1)));

   // R3
   quiet_before_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (!$past(out_valid, 2) && !$past(out_valid, 3) && !$past(out_valid, 4)));

   // R6
   sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> !out_byte[BYTE_W-1]);
endmodule

bind rsq_byte_engine rsq_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_byte(out_byte),
   .out_valid(out_valid), .out_last(out_last)
);

// File: tb/sim_rsq_byte_engine.sv
`timescale 1ns/1ps
module sim_rsq_byte_engine;
   localparam int PB = 11;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] in_byte;
   logic       in_valid;
   logic [7:0] out_byte;
   logic       out_valid, out_last;

   int  n_checks = 0;
   int  n_fails  = 0;
   int  cycles   = 0;
   bit  finished = 0;
   real tol;

   always #2.5 clk = ~clk;

   rsq_byte_engine #(.PRECISION_BITS(PB), .BYTE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
      .out_byte(out_byte), .out_valid(out_valid), .out_last(out_last)
   );

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not finish, act=%0d cycles exp<=150000", cycles);
         summary();
      end
   end

   task automatic check(input bit ok, input string req, input string detail);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s", req, detail);
      end
   endtask

   function automatic real fp_real(input logic [31:0] w);
      real v;
      int  e;
      v = 1.0 + real'(w[22:0]) / 8388608.0;
      e = int'(w[30:23]) - 127;
      for (int i = 0; i < e; i++) v = v * 2.0;
      for (int i = 0; i > e; i--) v = v * 0.5;
      return v;
   endfunction

   // Sends one operand (bytes separated by gap idle cycles), optionally
   // toggles in_valid while busy, and collects the result bytes.
   task automatic run_op(input logic [31:0] x, input int gap, input bit noise,
                         output logic [31:0] y, output bit proto_ok);
      proto_ok = 1;
      y = '0;
      for (int b = 0; b < 4; b++) begin
         for (int g = 0; g < gap; g++) begin
            in_valid = 0;
            in_byte  = 8'hC3;
            @(negedge clk);
            if (out_valid) proto_ok = 0;
         end
         in_byte  = x[31-8*b -: 8];
         in_valid = 1;
         @(negedge clk);
         if (out_valid) proto_ok = 0;
      end
      for (int k = 0; k < 4; k++) begin
         in_valid = noise;
         in_byte  = 8'(k * 37 + 11);
         if (out_valid || out_last) proto_ok = 0;
         @(negedge clk);
      end
      for (int k = 0; k < 4; k++) begin
         in_byte = 8'(k * 53 + 7);
         if (!out_valid || (out_last != (k == 3))) proto_ok = 0;
         y[31-8*k -: 8] = out_byte;
         if (k == 3) in_valid = 0;
         @(negedge clk);
      end
      if (out_valid || out_last) proto_ok = 0;
   endtask

   task automatic check_result(input logic [31:0] x, input logic [31:0] y);
      logic [31:0] sp;
      string       tag;
      bit          is_sp;
      real         r, g, rel;
      bit          shape_ok;
      is_sp = 1;
      if (x[30:23] == 8'hFF && x[22:0] != 0) begin sp = 32'h7FC00000; tag = "R7";  end
      else if (x[30:23] == 8'h00)            begin sp = 32'h7F800000; tag = "R8";  end
      else if (x[31])                        begin sp = 32'h7FC00000; tag = "R9";  end
      else if (x[30:23] == 8'hFF)            begin sp = 32'h00000000; tag = "R10"; end
      else begin is_sp = 0; sp = '0; tag = "R5 R6"; end
      if (is_sp) begin
         check(y == sp, tag, $sformatf("x=%h act=%h exp=%h", x, y, sp));
      end else begin
         r = 1.0 / $sqrt(fp_real(x));
         shape_ok = !y[31] && y[30:23] != 8'h00 && y[30:23] != 8'hFF;
         rel = 1.0;
         if (shape_ok) begin
            g = fp_real(y);
            rel = (g > r) ? (g - r) / r : (r - g) / r;
         end
         check(shape_ok && rel <= tol, tag,
               $sformatf("x=%h act=%h (rel err %f) exp=%e within %f", x, y, rel, r, tol));
      end
   endtask

   task automatic op_and_check(input logic [31:0] x, input int gap, input bit noise);
      logic [31:0] y;
      bit          pok;
      run_op(x, gap, noise, y, pok);
      check(pok, "R2 R3 R4", $sformatf("x=%h framing act=%0d exp=1", x, pok));
      check_result(x, y);
   endtask

   initial begin
      logic [31:0] fr_pat [8];
      tol = 0.00175 + 10.0 / real'(1 << PB);
      fr_pat[0] = 23'h000000; fr_pat[1] = 23'h7FFFFF; fr_pat[2] = 23'h400000;
      fr_pat[3] = 23'h123456; fr_pat[4] = 23'h6ABCDE; fr_pat[5] = 23'h000001;
      fr_pat[6] = 23'h3FFFFF; fr_pat[7] = 23'h555555;

      rst_n    = 0;
      in_valid = 0;
      in_byte  = 0;
      repeat (5) @(negedge clk);
      // R1: outputs quiet under reset
      check(!out_valid && !out_last, "R1",
            $sformatf("reset outputs act=%b%b exp=00", out_valid, out_last));
      rst_n = 1;
      @(negedge clk);

      // R1: reset in the middle of an operand discards the partial bytes
      in_byte = 8'hFF; in_valid = 1; @(negedge clk);
      in_byte = 8'hEE; @(negedge clk);
      in_valid = 0; rst_n = 0;
      repeat (2) @(negedge clk);
      check(!out_valid && !out_last, "R1",
            $sformatf("mid-operand reset act=%b%b exp=00", out_valid, out_last));
      rst_n = 1;
      op_and_check(32'h40800000, 0, 0);

      // R7 R8 R9 R10: special operand classes
      op_and_check(32'h00000000, 0, 0);
      op_and_check(32'h80000000, 1, 0);
      op_and_check(32'h00000001, 0, 0);
      op_and_check(32'h807FFFFF, 2, 0);
      op_and_check(32'hBF800000, 0, 0);
      op_and_check(32'hC2F00000, 0, 0);
      op_and_check(32'hFF800000, 0, 0);
      op_and_check(32'h7F800000, 0, 0);
      op_and_check(32'h7FC00000, 0, 0);
      op_and_check(32'h7F800001, 1, 0);
      op_and_check(32'hFFC00001, 0, 0);

      // R11: strobe noise while busy, then a clean operand right after
      op_and_check(32'h3F800000, 0, 1);
      op_and_check(32'h41100000, 0, 0);
      op_and_check(32'h7F800000, 0, 1);
      op_and_check(32'h3E800000, 0, 0);

      // R12: back-to-back operands with no idle cycle
      op_and_check(32'h40000000, 0, 0);
      op_and_check(32'h42C80000, 0, 0);

      // R2 R5 R6: sweep all normal exponents and several fractions
      for (int e = 1; e < 255; e++) begin
         for (int k = 0; k < 8; k++) begin
            op_and_check({1'b0, 8'(e), fr_pat[k][22:0]}, (e + k) % 3, (k == 5));
         end
      end

      summary();
   end
endmodule